// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block produces the row (common) scan sequence and the frame polarity for a small multiplexed LCD driver. Each pulse of a line-rate enable moves the scan to the next common line. After the last active line of a frame the scan returns to line 0, a one-cycle frame-start pulse is raised, and the polarity signal is inverted. As a result, one full AC drive cycle covers two frames.

The number of active commons per frame can be changed while the block runs. It is either all `NUM_COM` lines or one fewer, which is 1/4 or 1/3 duty with the default parameters. A new request is taken up only at a frame boundary. In slave mode the block follows a polarity signal from a master. Any edge on that signal forces the scan back to line 0, so the slave stays aligned with the master's frame. Each common output is given as a one-hot select bit, and also as a two-bit drive code (selected flag plus polarity) for the analog level stage.

Top module: `lcd_com_timing`

## Requirements
- R1: When reset is asserted, the block shows line 0, `com_sel_o` = 1 on bit 0, `fr_o` = 0 and `frame_start_o` = 0, and full duty (`NUM_COM` lines) is in force.
- R2: In master mode, a clock with `line_en_i` high moves `line_o` up by one on the next edge. A clock with `line_en_i` low leaves `line_o` unchanged.
- R3: At full duty the scan wraps to line 0 after line `NUM_COM-1`. At short duty (`duty_short_i` = 1) it wraps after line `NUM_COM-2`, and the last common is never selected.
- R4: `frame_start_o` is high for exactly the one cycle in which `line_o` returns to 0.
- R5: In master mode, `fr_o` inverts at every frame wrap and at no other time.
- R6: A change of `duty_short_i` takes effect only when a frame wraps or is re-locked. The frame in progress completes with its old line count.
- R7: In slave mode, a change of level on `fr_ext_i` sets `line_o` to 0 and pulses `frame_start_o` on the next edge. `fr_o` follows `fr_ext_i` one cycle later.
- R8: `com_sel_o` is one-hot, with the bit at index `line_o` set.
- R9: For each common k, `com_drv_o[2k+1]` is the select bit of line k and `com_drv_o[2k]` equals `fr_o`.
- R10: In slave mode, an external edge wins over `line_en_i` in the same cycle, so the line goes to 0 and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_en_i | input | 1 | Line-rate step enable |
| duty_short_i | input | 1 | Requested duty: 1 = NUM_COM-1 lines, 0 = NUM_COM lines |
| slave_i | input | 1 | 1 = lock to external polarity |
| fr_ext_i | input | 1 | Polarity from master |
| com_sel_o | output | NUM_COM | One-hot active common |
| line_o | output | LINE_W | Current line index |
| fr_o | output | 1 | Frame polarity |
| frame_start_o | output | 1 | One-cycle pulse at frame start |
| com_drv_o | output | 2*NUM_COM | Per-common {selected, polarity} code |

## Verification
The hardest case to reach from the ports is a duty request that changes in the middle of a frame, because its effect only appears one wrap later. The stimulus table therefore raises and later drops `duty_short_i` partway through a frame, then counts the lines of that frame and of the following one. Slave re-lock is driven in three positions: on a cycle that also steps, just after a normal wrap, and in the middle of a frame. Reset is applied after short duty has been loaded, to show that the duty setting goes back to full.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
  typedef enum logic {
    DUTY_FULL  = 1'b0,
    DUTY_SHORT = 1'b1
  } duty_e;
endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
  import lcd_com_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int LINE_W  = $clog2(NUM_COM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              relock_i,
  input  duty_e             duty_req_i,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_start_o,
  output logic              wrap_o
);
  localparam logic [LINE_W-1:0] LAST_FULL  = LINE_W'(NUM_COM - 1);
  localparam logic [LINE_W-1:0] LAST_SHORT = LINE_W'(NUM_COM - 2);

  duty_e             duty_q;
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] last_line;
  logic              fs_q;

  assign last_line = (duty_q == DUTY_SHORT) ? LAST_SHORT : LAST_FULL;
  assign wrap_o    = step_i & ~relock_i & (line_q == last_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      duty_q <= DUTY_FULL;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      if (relock_i) begin
        line_q <= '0;
        duty_q <= duty_req_i;
        fs_q   <= 1'b1;
      end else if (step_i) begin
        if (line_q == last_line) begin
          line_q <= '0;
          duty_q <= duty_req_i;  // duty only swaps at a boundary
          fs_q   <= 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end
    end
  end

  assign line_o        = line_q;
  assign frame_start_o = fs_q;
endmodule

// File: rtl/lcd_fr_gen.sv
module lcd_fr_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic fr_ext_i,
  input  logic wrap_i,
  output logic fr_o,
  output logic relock_o
);
  logic fr_ext_q;
  logic fr_q;

  // plain history flop: edge reference equals the previous sample
  always_ff @(posedge clk_i) begin
    fr_ext_q <= fr_ext_i;
  end

  assign relock_o = slave_i & (fr_ext_i ^ fr_ext_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q <= 1'b0;
    end else if (slave_i) begin
      fr_q <= fr_ext_i;
    end else if (wrap_i) begin
      fr_q <= ~fr_q;
    end
  end

  assign fr_o = fr_q;
endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode #(
  parameter int NUM_COM = 4,
  parameter int LINE_W  = $clog2(NUM_COM)
) (
  input  logic [LINE_W-1:0]    line_i,
  input  logic                 fr_i,
  output logic [NUM_COM-1:0]   com_sel_o,
  output logic [2*NUM_COM-1:0] com_drv_o
);
  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    assign com_sel_o[k]     = (line_i == LINE_W'(k));
    assign com_drv_o[2*k+1] = com_sel_o[k];
    assign com_drv_o[2*k]   = fr_i;
  end
endmodule

// File: rtl/lcd_com_timing.sv
module lcd_com_timing
  import lcd_com_pkg::*;
#(
  parameter int NUM_COM = 4,
  localparam int LINE_W = $clog2(NUM_COM)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_en_i,
  input  logic                 duty_short_i,
  input  logic                 slave_i,
  input  logic                 fr_ext_i,
  output logic [NUM_COM-1:0]   com_sel_o,
  output logic [LINE_W-1:0]    line_o,
  output logic                 fr_o,
  output logic                 frame_start_o,
  output logic [2*NUM_COM-1:0] com_drv_o
);
  logic  wrap;
  logic  relock;
  duty_e duty_req;

  assign duty_req = duty_short_i ? DUTY_SHORT : DUTY_FULL;

  lcd_line_ctr #(.NUM_COM(NUM_COM), .LINE_W(LINE_W)) u_line_ctr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (line_en_i),
    .relock_i      (relock),
    .duty_req_i    (duty_req),
    .line_o        (line_o),
    .frame_start_o (frame_start_o),
    .wrap_o        (wrap)
  );

  lcd_fr_gen u_fr_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slave_i  (slave_i),
    .fr_ext_i (fr_ext_i),
    .wrap_i   (wrap),
    .fr_o     (fr_o),
    .relock_o (relock)
  );

  lcd_com_decode #(.NUM_COM(NUM_COM), .LINE_W(LINE_W)) u_decode (
    .line_i    (line_o),
    .fr_i      (fr_o),
    .com_sel_o (com_sel_o),
    .com_drv_o (com_drv_o)
  );
endmodule

// File: rtl/lcd_com_timing_chk.sv
module lcd_com_timing_chk #(
  parameter int NUM_COM = 4,
  localparam int LINE_W = $clog2(NUM_COM)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 line_en_i,
  input logic                 duty_short_i,
  input logic                 slave_i,
  input logic                 fr_ext_i,
  input logic [NUM_COM-1:0]   com_sel_o,
  input logic [LINE_W-1:0]    line_o,
  input logic                 fr_o,
  input logic                 frame_start_o,
  input logic [2*NUM_COM-1:0] com_drv_o
);
  assert_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(com_sel_o) == 1) && com_sel_o[line_o]);

  assert_fs_at_line0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_o == '0));

  assert_fr_only_at_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !$past(slave_i) && (fr_o != $past(fr_o))) |-> frame_start_o);

  assert_hold_no_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && !line_en_i) |=> $stable(line_o));

  assert_relock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i && (fr_ext_i != $past(fr_ext_i))) |=>
      ((line_o == '0) && frame_start_o && (fr_o == $past(fr_ext_i))));

  for (genvar k = 0; k < NUM_COM; k++) begin : g_drv
    assert_drv_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (com_drv_o[2*k] == fr_o) && (com_drv_o[2*k+1] == com_sel_o[k]));
  end
endmodule

bind lcd_com_timing lcd_com_timing_chk #(.NUM_COM(NUM_COM)) u_chk (.*);

// File: tb/lcd_com_timing_tb.sv
module lcd_com_timing_tb;
  localparam int NUM_COM = 4;
  localparam int LINE_W  = 2;
  localparam int NVEC    = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line_en = 1'b0, duty_short = 1'b0, slave = 1'b0, fr_ext = 1'b0;
  logic [NUM_COM-1:0]   com_sel;
  logic [LINE_W-1:0]    line;
  logic                 fr, fs;
  logic [2*NUM_COM-1:0] com_drv;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lcd_com_timing #(.NUM_COM(NUM_COM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_en_i(line_en), .duty_short_i(duty_short),
    .slave_i(slave), .fr_ext_i(fr_ext), .com_sel_o(com_sel), .line_o(line),
    .fr_o(fr), .frame_start_o(fs), .com_drv_o(com_drv)
  );

  // {en, duty_short, slave, fr_ext} | {line[1:0], fr, fs}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1000_01_0_0, 8'b1000_10_0_0, 8'b1000_11_0_0, 8'b1000_00_1_1, // R2 R3 R4 R5
    8'b0000_00_1_0,                                                 // R2 hold
    8'b1100_01_1_0, 8'b1100_10_1_0, 8'b1100_11_1_0, 8'b1100_00_0_1, // R6 old duty finishes
    8'b1100_01_0_0, 8'b1100_10_0_0, 8'b1100_00_1_1,                 // R3 short wrap
    8'b1000_01_1_0, 8'b1000_10_1_0, 8'b1000_00_0_1,                 // R6 short frame completes
    8'b1000_01_0_0, 8'b1000_10_0_0, 8'b1000_11_0_0,                 // R6 full again
    8'b0010_11_0_0,                                                 // slave, no edge
    8'b1011_00_1_1,                                                 // R10 edge beats step
    8'b1011_01_1_0, 8'b1011_10_1_0, 8'b1011_11_1_0, 8'b1011_00_1_1,
    8'b0010_00_0_1,                                                 // R7 falling edge
    8'b1010_01_0_0, 8'b0011_00_1_1,                                 // R7 mid-frame relock
    8'b0001_00_1_0, 8'b1001_01_1_0, 8'b1001_10_1_0                  // back to master
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req, input logic [1:0] el, input logic ef,
                             input logic efs);
    logic [NUM_COM-1:0]   es;
    logic [2*NUM_COM-1:0] ed;
    es = '0;
    es[el] = 1'b1;
    for (int k = 0; k < NUM_COM; k++) begin
      ed[2*k+1] = es[k];
      ed[2*k]   = ef;
    end
    chk({req, " line"}, 32'(line), 32'(el));
    chk({req, " fr"}, 32'(fr), 32'(ef));
    chk({req, " frame_start"}, 32'(fs), 32'(efs));
    chk("R8 com_sel", 32'(com_sel), 32'(es));
    chk("R9 com_drv", 32'(com_drv), 32'(ed));
  endtask

  task automatic drive(input logic [3:0] in);
    {line_en, duty_short, slave, fr_ext} = in;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_outputs("R1 reset", 2'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][7:4]);
      chk_outputs($sformatf("vec%0d R2/R3/R5/R6/R7/R10", i), VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end
    // R2: hold over several idle cycles
    for (int i = 0; i < 5; i++) begin
      drive(4'b0000);
      chk("R2 idle hold", 32'(line), 32'd2);
    end
    // load short duty, then reset: R1 full duty restored
    drive(4'b1100);                                  // line 3? no: from 2 -> 3 (full)
    drive(4'b1100);                                  // wrap, loads short
    chk("R3 wrap before reset", 32'(fs), 32'd1);
    #2 rst_ni = 1'b0;
    #1 chk_outputs("R1 async reset", 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(4'b1000);
    drive(4'b1000);
    drive(4'b1000);
    chk("R1 full duty after reset", 32'(line), 32'd3);
    drive(4'b1000);
    chk_outputs("R3 R4 full wrap after reset", 2'd0, 1'b1, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule